// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits between a CPU-side request port and a backing memory port. It makes every bit of two backing regions addressable as its own word inside a 32 MiB alias window. A request whose address falls in an alias window is translated to a backing byte address and a bit index. A read fetches the access-sized backing data and returns only the selected bit. A write reads the backing data, forces the selected bit to the requested value, and writes the full access-sized data back.

Each request is handled one at a time by a small sequencer. The requester raises `s_valid` with its request fields and holds them. The bridge raises `s_ready` for exactly one cycle once the result, data and error flag together, is available. On the backing side the bridge issues a request and holds it until `m_ready` accepts it. It then waits for a one-cycle `m_rvalid` response, which carries read data and an error flag. Backing data is little-endian and right-justified: byte lane 0 of `m_rdata`/`m_wdata` holds the lowest address of the access.

Top module: `bitband_bridge`

## Requirements
- R1: After reset, `s_ready` and `m_valid` are both low until a request arrives.
- R2: Window A (alias base 0x22000000) maps onto backing base 0x20000000, and window B (alias base 0x42000000) maps onto backing base 0x40000000. Only the low 25 address bits (the offset) take part in translation. The backing address is the backing base ORed with offset>>5, then rounded down to a multiple of the access size. That address appears on `m_addr` with `m_size` equal to the request size.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The bit index into the backing data is (offset>>2) masked to the access width in bits (7, 15 or 31). Its byte lane is index>>3 and its bit within the byte is index&7.
- R4: A successful read responds with the selected backing bit in `s_rdata[0]`, with all other bits zero and `s_err` low.
- R5: A write sets the selected bit if `s_wbit` is 1 and clears it if 0. It writes back `m_wdata` holding the read data with only that bit changed; bytes above the access size are zero. A write responds with `s_rdata` zero.
- R6: Size code 3 responds with `s_err` high and issues no backing access.
- R7: An address outside both windows responds with `s_err` high and issues no backing access.
- R8: A backing read error is returned on `s_err`, and no write-back is issued.
- R9: A backing write-back error is returned on `s_err`.
- R10: `m_valid` and its address, size, direction and write data stay unchanged from the cycle they are raised until `m_ready` accepts them.
- R11: `s_ready` is high for exactly one cycle per request and stays low while the backing access is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request present, held until `s_ready` |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | 32 | Alias address |
| s_size | input | 2 | Size code: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| s_wbit | input | 1 | Bit value to store on a write |
| s_ready | output | 1 | One-cycle completion strobe |
| s_rdata | output | 32 | Selected bit in bit 0 |
| s_err | output | 1 | Error response |
| m_valid | output | 1 | Backing request |
| m_write | output | 1 | Backing request is a write |
| m_addr | output | 32 | Backing byte address |
| m_size | output | 2 | Backing size code |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_ready | input | 1 | Backing request accepted |
| m_rvalid | input | 1 | Backing response strobe |
| m_rdata | input | 32 | Backing read data, right-justified |
| m_err | input | 1 | Backing response error |

## Verification
The assertions assume that the requester holds `s_valid` and its fields steady until `s_ready`, and drops `s_valid` in the cycle after it. They also assume that the backing side gives exactly one `m_rvalid` per accepted request and never gives one unprompted. The bench's backing model answers only after it has granted a request and never overlaps two responses. Its requester task raises one request at a time and releases it on the completion strobe. Stall lengths, response latencies and error injection vary within those limits.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter int          OFS_BITS  = 25,
  parameter logic [31:0] WA_ALIAS  = 32'h2200_0000,
  parameter logic [31:0] WA_BACK   = 32'h2000_0000,
  parameter logic [31:0] WB_ALIAS  = 32'h4200_0000,
  parameter logic [31:0] WB_BACK   = 32'h4000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_write,
  input  logic [31:0] s_addr,
  input  logic [1:0]  s_size,
  input  logic        s_wbit,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        s_err,
  output logic        m_valid,
  output logic        m_write,
  output logic [31:0] m_addr,
  output logic [1:0]  m_size,
  output logic [31:0] m_wdata,
  input  logic        m_ready,
  input  logic        m_rvalid,
  input  logic [31:0] m_rdata,
  input  logic        m_err
);

  typedef enum logic [2:0] {IDLE, RD_REQ, RD_WAIT, WR_REQ, WR_WAIT, RESP} seq_t;

  seq_t        st;
  logic        q_write, q_bit, q_rbit, q_err;
  logic [1:0]  q_size;
  logic [4:0]  q_bidx;
  logic [31:0] q_baddr, q_data;

  logic [OFS_BITS-1:0] ofs;
  logic        hit_a, hit_b, legal;
  logic [31:0] back_base, raw_addr, align_mask, lane_mask, patched;
  logic [4:0]  bidx;

  assign ofs        = s_addr[OFS_BITS-1:0];
  assign hit_a      = s_addr[31:OFS_BITS] == WA_ALIAS[31:OFS_BITS];
  assign hit_b      = s_addr[31:OFS_BITS] == WB_ALIAS[31:OFS_BITS];
  assign legal      = (hit_a || hit_b) && (s_size != 2'd3);
  assign back_base  = hit_a ? WA_BACK : WB_BACK;
  assign raw_addr   = back_base | 32'(ofs >> 5);
  assign align_mask = ~((32'd1 << s_size) - 32'd1);
  assign bidx       = ofs[6:2] & {s_size == 2'd2, s_size != 2'd0, 3'b111};

  always_comb begin
    case (q_size)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  end

  assign patched = ((m_rdata & ~(32'd1 << q_bidx)) | ({31'd0, q_bit} << q_bidx)) & lane_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      q_write <= 1'b0;
      q_bit   <= 1'b0;
      q_rbit  <= 1'b0;
      q_err   <= 1'b0;
      q_size  <= 2'd0;
      q_bidx  <= 5'd0;
      q_baddr <= 32'd0;
      q_data  <= 32'd0;
    end else begin
      case (st)
        IDLE: if (s_valid) begin
          q_write <= s_write;
          q_size  <= s_size;
          q_bit   <= s_wbit;
          q_baddr <= raw_addr & align_mask;
          q_bidx  <= bidx;
          q_rbit  <= 1'b0;
          q_data  <= 32'd0;
          q_err   <= !legal;
          st      <= legal ? RD_REQ : RESP;
        end
        RD_REQ: if (m_ready) st <= RD_WAIT;
        RD_WAIT: if (m_rvalid) begin
          if (m_err) begin
            q_err <= 1'b1;
            st    <= RESP;
          end else if (q_write) begin
            q_data <= patched;
            st     <= WR_REQ;
          end else begin
            q_rbit <= m_rdata[q_bidx];
            st     <= RESP;
          end
        end
        WR_REQ: if (m_ready) st <= WR_WAIT;
        WR_WAIT: if (m_rvalid) begin
          q_err <= m_err;
          st    <= RESP;
        end
        RESP: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assign m_valid = (st == RD_REQ) || (st == WR_REQ);
  assign m_write = (st == WR_REQ);
  assign m_addr  = q_baddr;
  assign m_size  = q_size;
  assign m_wdata = q_data;
  assign s_ready = (st == RESP);
  assign s_rdata = {31'd0, q_rbit};
  assign s_err   = q_err;

  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_write)
                            && $stable(m_size) && $stable(m_wdata));

  a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  a_r11_quiet_during_access: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  a_r6_no_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_size != 2'd3);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_size == 2'd0) || (m_size == 2'd1 && !m_addr[0])
                || (m_size == 2'd2 && m_addr[1:0] == 2'b00));

  a_r8_wb_after_good_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid && m_write) |-> $past(m_rvalid && !m_err));

  a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> s_rdata[31:1] == 31'd0);

endmodule

// File: tb/bitband_bridge_bench.sv
`timescale 1ns/1ps
module bitband_bridge_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_write = 1'b0, s_wbit = 1'b0;
  logic [31:0] s_addr = '0;
  logic [1:0]  s_size = '0;
  logic s_ready, s_err, m_valid, m_write;
  logic [31:0] s_rdata, m_addr, m_wdata;
  logic [1:0]  m_size;
  logic m_ready = 1'b0, m_rvalid = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2 clk = ~clk;

  bitband_bridge u_bitband_bridge (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  byte unsigned mem [int unsigned];
  byte unsigned ref_mem [int unsigned];
  int n_rd = 0, n_wr = 0;
  logic [31:0] x_addr, x_wdata;
  logic [1:0]  x_size;
  bit inj_rd_err = 0, inj_wr_err = 0;
  int stall_set = 0, lat_set = 0, stall = 0, lat = 0;
  bit busy = 0;
  string cur_req = "";

  function automatic byte unsigned memb(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic byte unsigned refb(int unsigned a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic poke(int unsigned a, byte unsigned v);
    mem[a] = v;
    ref_mem[a] = v;
  endtask

  // backing memory model, driven away from the active edge
  always @(negedge clk) begin
    m_rvalid = 1'b0;
    m_ready  = 1'b0;
    if (!rst_n) begin
      busy = 0;
    end else if (busy) begin
      if (lat == 0) begin
        m_rvalid = 1'b1;
        busy = 0;
      end else lat--;
    end else if (m_valid) begin
      if (stall > 0) stall--;
      else begin
        int n;
        m_ready = 1'b1;
        busy = 1;
        lat = lat_set;
        stall = stall_set;
        n = 1 << m_size;
        check(m_addr == x_addr, {cur_req, " R2"}, "backing address", m_addr, x_addr);
        check(m_size == x_size, {cur_req, " R2"}, "backing size", {30'd0, m_size}, {30'd0, x_size});
        if (m_write) begin
          n_wr++;
          check(m_wdata == x_wdata, {cur_req, " R5"}, "write-back data", m_wdata, x_wdata);
          m_err = inj_wr_err;
          m_rdata = 32'h0;
          if (!inj_wr_err)
            for (int i = 0; i < n; i++) mem[m_addr + i] = m_wdata[8*i +: 8];
        end else begin
          n_rd++;
          m_err = inj_rd_err;
          m_rdata = 32'hA5A5_A5A5;
          for (int i = 0; i < n; i++) m_rdata[8*i +: 8] = memb(m_addr + i);
        end
      end
    end
  end

  task automatic acc(bit wr, logic [31:0] a, logic [1:0] sz, bit wb,
                     bit rerr, bit werr, string req);
    bit legal, win_a;
    logic [31:0] base, off, ba, exp_data;
    int n, bi, lane, bp, rd0, wr0, exp_rd, exp_wr, guard;
    bit exp_err, cur;
    byte unsigned nb;
    win_a = a[31:25] == 7'h11;
    legal = (win_a || a[31:25] == 7'h21) && sz != 2'd3;
    base = win_a ? 32'h2000_0000 : 32'h4000_0000;
    off = {7'd0, a[24:0]};
    n = 1 << sz;
    ba = (base | (off >> 5)) & ~(n - 1);
    bi = (off >> 2) & (n * 8 - 1);
    lane = bi >> 3;
    bp = bi & 7;
    cur = refb(ba + lane) >> bp;
    nb = wb ? (refb(ba + lane) | (8'd1 << bp)) : (refb(ba + lane) & ~(8'd1 << bp));
    x_addr = ba; x_size = sz; x_wdata = 32'd0;
    for (int i = 0; i < n; i++) x_wdata[8*i +: 8] = (i == lane) ? nb : refb(ba + i);
    inj_rd_err = rerr; inj_wr_err = werr;
    exp_err = !legal || rerr || (wr && werr);
    exp_data = (!wr && legal && !rerr) ? {31'd0, cur} : 32'd0;
    exp_rd = legal ? 1 : 0;
    exp_wr = (legal && wr && !rerr) ? 1 : 0;
    if (legal && wr && !rerr && !werr) ref_mem[ba + lane] = nb;
    rd0 = n_rd; wr0 = n_wr; cur_req = req;
    @(negedge clk);
    s_valid = 1'b1; s_write = wr; s_addr = a; s_size = sz; s_wbit = wb;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!s_ready && guard < 200);
    check(s_ready, req, "completion strobe", {31'd0, s_ready}, 32'd1);
    check(s_err == exp_err, req, "error flag", {31'd0, s_err}, {31'd0, exp_err});
    check(s_rdata == exp_data, req, "read data", s_rdata, exp_data);
    s_valid = 1'b0;
    @(negedge clk);
    check(!s_ready, {req, " R11"}, "strobe width", {31'd0, s_ready}, 32'd0);
    check(n_rd - rd0 == exp_rd, req, "backing reads", n_rd - rd0, exp_rd);
    check(n_wr - wr0 == exp_wr, req, "backing writes", n_wr - wr0, exp_wr);
    if (legal) check(memb(ba + lane) == refb(ba + lane), {req, " R5"}, "backing byte",
                     {24'd0, memb(ba + lane)}, {24'd0, refb(ba + lane)});
    inj_rd_err = 0; inj_wr_err = 0;
  endtask

  function automatic logic [31:0] alias_of(logic [31:0] win, int byte_ofs, int bitn);
    return win | (byte_ofs << 5) | (bitn << 2);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not complete");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      poke(32'h2000_0100 + i, 8'(i * 37 + 5));
      poke(32'h4000_0200 + i, 8'(i * 91 + 3));
    end
    repeat (3) @(negedge clk);
    check(!s_ready && !m_valid, "R1", "idle after reset", {30'd0, s_ready, m_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!s_ready && !m_valid, "R1", "idle after release", {30'd0, s_ready, m_valid}, 32'd0);

    acc(0, alias_of(32'h2200_0000, 32'h100, 3), 2'd0, 0, 0, 0, "R4 R2 byte read A");
    acc(0, alias_of(32'h2200_0000, 32'h105, 6), 2'd1, 0, 0, 0, "R3 R4 half read lane1");
    acc(0, alias_of(32'h2200_0000, 32'h10B, 2), 2'd2, 0, 0, 0, "R3 R4 word read lane3");
    acc(0, alias_of(32'h4200_0000, 32'h203, 5), 2'd0, 0, 0, 0, "R2 R4 byte read B");
    acc(1, alias_of(32'h4200_0000, 32'h201, 7), 2'd0, 1, 0, 0, "R5 set bit B");
    acc(0, alias_of(32'h4200_0000, 32'h201, 7), 2'd0, 0, 0, 0, "R5 R4 readback set");
    acc(1, alias_of(32'h2200_0000, 32'h10E, 0), 2'd2, 0, 0, 0, "R5 clear bit word");
    acc(1, alias_of(32'h4200_0000, 32'h20A, 4), 2'd1, 1, 0, 0, "R5 R3 half write");
    stall_set = 3; lat_set = 2;
    acc(0, alias_of(32'h2200_0000, 32'h10E, 0), 2'd2, 0, 0, 0, "R10 R4 stalled read");
    acc(1, alias_of(32'h2200_0000, 32'h120, 1), 2'd1, 1, 0, 0, "R10 R5 stalled write");
    stall_set = 0; lat_set = 0;
    acc(0, alias_of(32'h2200_0000, 32'h100, 0), 2'd3, 0, 0, 0, "R6 illegal size");
    acc(1, alias_of(32'h2200_0000, 32'h100, 0), 2'd3, 1, 0, 0, "R6 illegal size write");
    acc(0, 32'h3000_0040, 2'd0, 0, 0, 0, "R7 outside windows");
    acc(1, 32'h2000_0040, 2'd2, 1, 0, 0, "R7 backing address direct");
    acc(0, alias_of(32'h2200_0000, 32'h101, 1), 2'd0, 0, 1, 0, "R8 read error");
    acc(1, alias_of(32'h2200_0000, 32'h101, 1), 2'd0, 1, 1, 0, "R8 write with read error");
    acc(1, alias_of(32'h4200_0000, 32'h210, 3), 2'd2, 1, 0, 1, "R9 write-back error");
    acc(0, 32'h23FF_FFFC, 2'd0, 0, 0, 0, "R2 top of window read");
    acc(1, 32'h23FF_FFFC, 2'd0, 1, 0, 0, "R2 top of window write");
    acc(0, 32'h23FF_FFFC, 2'd2, 0, 0, 0, "R3 top of window word");
    for (int k = 0; k < 40; k++) begin
      logic [31:0] win;
      int bo, bn;
      logic [1:0] sz;
      win = (k % 3 == 0) ? 32'h4200_0000 : 32'h2200_0000;
      bo  = ((win == 32'h4200_0000) ? 32'h200 : 32'h100) + ($urandom % 64);
      bn  = $urandom % 8;
      sz  = 2'($urandom % 3);
      stall_set = $urandom % 3; lat_set = $urandom % 3;
      acc(k[0], alias_of(win, bo, bn), sz, 1'($urandom % 2), 0, 0, "R3 R5 mixed traffic");
    end
    summary();
  end
endmodule